// File: doc/BRIEF.md
# Divide special-case resolver

This block sits in front of a floating-point divider. It receives the class and sign of two operands, a destination operand and a source operand. It decides whether the quotient follows from the operand classes alone or needs the full mantissa divider. When the class is enough, it gives the class and sign of the result. It also raises the invalid-operation and zero-divide flags, and it says whether the result is to be written back. When both operands are finite and nonzero, it raises a normal-path signal and leaves every flag low. The downstream divider then produces the value.

The destination is normally the dividend. A reverse flag makes the source the dividend and the destination the divisor, and this swap happens before any classification. An integer-source flag marks the source as a converted integer, so a source zero from that path always counts as positive. A mask bit chooses how a zero divide is handled. When the mask is set, a signed infinity is stored. When it is clear, nothing is stored.

Operands arrive on a valid/ready stream, and verdicts leave on a second valid/ready stream through one register stage. An operand pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its contents are taken on the same edge. While `out_valid` is high and `out_ready` is low, the verdict stays in place unchanged and no new operand pair is accepted. The block has no mantissa arithmetic, no rounding, no denormal handling and no overflow or underflow detection.

Top module: `fdiv_special_resolver`

## Requirements
- R1: Class codes on every class port are 0 = zero, 1 = finite nonzero, 2 = infinity, 3 = NaN. Infinity divided by infinity, for any signs, gives class NaN with sign 1, `flag_invalid` = 1 and `store_en` = 1.
- R2: Zero divided by zero, for any signs, gives class NaN with sign 1, `flag_invalid` = 1 and `store_en` = 1.
- R3: A finite nonzero dividend over a zero divisor sets `flag_zdiv` = 1 and gives class infinity. The result sign is the XOR of the two operand signs. `store_en` equals `zd_masked`, so when the mask is clear nothing is stored.
- R4: A finite dividend over an infinite divisor gives zero. A zero dividend over a finite or infinite divisor also gives zero. In both cases the sign is the XOR of the operand signs, no flag is raised and `store_en` = 1.
- R5: An infinite dividend over a finite or zero divisor gives infinity with the XOR sign. No flag is raised and `store_en` = 1.
- R6: If either operand is NaN, the result is class NaN. Its sign is that of the dividend when the dividend is NaN, and otherwise that of the divisor. `flag_invalid` = 1 only if a NaN operand has its signaling bit set. `store_en` = 1.
- R7: When `int_source` = 1 and the source class is zero, the source sign counts as 0, whatever `src_sign` is.
- R8: When `rev_mode` = 1, the source is the dividend and the destination is the divisor. When `rev_mode` = 0, the destination is the dividend.
- R9: When both operands are finite and nonzero, `normal_path` = 1, the class is finite, the sign is the XOR sign, `store_en` = 1 and both flags are 0. In every other case `normal_path` = 0.
- R10: A verdict appears on the output one clock edge after its operands are accepted. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs hold steady.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Operand pair can be taken |
| dst_cls | input | 2 | Destination operand class code |
| dst_sign | input | 1 | Destination operand sign |
| dst_snan | input | 1 | Destination NaN is signaling |
| src_cls | input | 2 | Source operand class code |
| src_sign | input | 1 | Source operand sign |
| src_snan | input | 1 | Source NaN is signaling |
| rev_mode | input | 1 | Source becomes the dividend |
| int_source | input | 1 | Source came from an integer |
| zd_masked | input | 1 | Zero-divide is masked |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| res_cls | output | 2 | Result class code |
| res_sign | output | 1 | Result sign |
| flag_invalid | output | 1 | Invalid-operation raised |
| flag_zdiv | output | 1 | Zero-divide raised |
| store_en | output | 1 | Result is to be written back |
| normal_path | output | 1 | Send operands to the full divider |

## Verification
Each verdict is due on the rising edge after its operand pair is accepted. It stays valid until a rising edge where `out_ready` is high. The bench computes the expected verdict when the driver sees `in_ready` high just after a falling edge, and it queues that verdict. The monitor pops and compares an entry only at a falling edge where `out_valid` and `out_ready` are both high, because that verdict is the one consumed on the next rising edge. A pseudo-random `out_ready` pattern creates stalls. At each sample that follows a stall, the bench checks that the held verdict has not changed.

// File: rtl/fdsc_pkg.sv
package fdsc_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  typedef struct packed {
    cls_e cls;
    logic sign;
    logic snan;
  } opnd_t;

  typedef struct packed {
    cls_e cls;
    logic sign;
    logic invalid;
    logic zdiv;
    logic store;
    logic normal;
  } verdict_t;

  localparam int VERDICT_W = $bits(verdict_t);

endpackage

// File: rtl/fdsc_operand_map.sv
module fdsc_operand_map
  import fdsc_pkg::*;
(
  input  opnd_t dst,
  input  opnd_t src,
  input  logic  reverse,
  input  logic  int_src,
  output opnd_t dividend,
  output opnd_t divisor
);

  opnd_t src_fixed;

  // Integer zero has no sign of its own: it is always positive.
  always_comb begin
    src_fixed = src;
    if (int_src && src.cls == CLS_ZERO) src_fixed.sign = 1'b0;
  end

  always_comb begin
    if (reverse) begin
      dividend = src_fixed;
      divisor  = dst;
    end else begin
      dividend = dst;
      divisor  = src_fixed;
    end
  end

endmodule

// File: rtl/fdsc_class_table.sv
module fdsc_class_table
  import fdsc_pkg::*;
#(
  parameter logic INDEF_SIGN = 1'b1
) (
  input  opnd_t    dividend,
  input  opnd_t    divisor,
  input  logic     zd_mask,
  output verdict_t verdict
);

  logic x_sign;
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, a_fin, b_fin;

  assign x_sign = dividend.sign ^ divisor.sign;
  assign a_nan  = dividend.cls == CLS_NAN;
  assign b_nan  = divisor.cls  == CLS_NAN;
  assign a_inf  = dividend.cls == CLS_INF;
  assign b_inf  = divisor.cls  == CLS_INF;
  assign a_zero = dividend.cls == CLS_ZERO;
  assign b_zero = divisor.cls  == CLS_ZERO;
  assign a_fin  = dividend.cls == CLS_FIN;
  assign b_fin  = divisor.cls  == CLS_FIN;

  always_comb begin
    verdict = '{cls: CLS_FIN, sign: x_sign, invalid: 1'b0,
                zdiv: 1'b0, store: 1'b1, normal: 1'b0};
    if (a_nan || b_nan) begin
      verdict.cls     = CLS_NAN;
      verdict.sign    = a_nan ? dividend.sign : divisor.sign;
      verdict.invalid = (a_nan && dividend.snan) || (b_nan && divisor.snan);
    end else if ((a_inf && b_inf) || (a_zero && b_zero)) begin
      verdict.cls     = CLS_NAN;
      verdict.sign    = INDEF_SIGN;
      verdict.invalid = 1'b1;
    end else if (a_fin && b_zero) begin
      verdict.cls   = CLS_INF;
      verdict.zdiv  = 1'b1;
      verdict.store = zd_mask;
    end else if (a_inf) begin
      verdict.cls = CLS_INF;
    end else if (b_inf || a_zero) begin
      verdict.cls = CLS_ZERO;
    end else begin
      verdict.normal = 1'b1;
    end
  end

  always_comb begin
    if (a_fin && b_fin)
      p_fin_pair_normal_r9: assert (verdict.normal && !verdict.invalid && !verdict.zdiv);
  end

endmodule

// File: rtl/fdsc_out_stage.sv
module fdsc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_take_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));

endmodule

// File: rtl/fdiv_special_resolver.sv
module fdiv_special_resolver
  import fdsc_pkg::*;
#(
  parameter logic INDEF_SIGN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] dst_cls,
  input  logic       dst_sign,
  input  logic       dst_snan,
  input  logic [1:0] src_cls,
  input  logic       src_sign,
  input  logic       src_snan,
  input  logic       rev_mode,
  input  logic       int_source,
  input  logic       zd_masked,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] res_cls,
  output logic       res_sign,
  output logic       flag_invalid,
  output logic       flag_zdiv,
  output logic       store_en,
  output logic       normal_path
);

  opnd_t    dst_op, src_op, dvd, dvs;
  verdict_t comb_v, reg_v;
  logic [VERDICT_W-1:0] reg_bits;

  assign dst_op = '{cls: cls_e'(dst_cls), sign: dst_sign, snan: dst_snan};
  assign src_op = '{cls: cls_e'(src_cls), sign: src_sign, snan: src_snan};

  fdsc_operand_map u_map (
    .dst      (dst_op),
    .src      (src_op),
    .reverse  (rev_mode),
    .int_src  (int_source),
    .dividend (dvd),
    .divisor  (dvs)
  );

  fdsc_class_table #(.INDEF_SIGN(INDEF_SIGN)) u_table (
    .dividend (dvd),
    .divisor  (dvs),
    .zd_mask  (zd_masked),
    .verdict  (comb_v)
  );

  fdsc_out_stage #(.W(VERDICT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_v),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (reg_bits)
  );

  assign reg_v        = verdict_t'(reg_bits);
  assign res_cls      = reg_v.cls;
  assign res_sign     = reg_v.sign;
  assign flag_invalid = reg_v.invalid;
  assign flag_zdiv    = reg_v.zdiv;
  assign store_en     = reg_v.store;
  assign normal_path  = reg_v.normal;

  p_zdiv_gives_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_zdiv |-> res_cls == CLS_INF && !flag_invalid && !normal_path);

  p_nostore_only_zdiv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !store_en |-> flag_zdiv);

  p_invalid_is_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_invalid |-> res_cls == CLS_NAN);

  p_normal_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && normal_path |-> res_cls == CLS_FIN && store_en && !flag_invalid && !flag_zdiv);

  p_accept_gives_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

endmodule

// File: tb/sim_fdiv_special_resolver.sv
module sim_fdiv_special_resolver;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] dst_cls = '0, src_cls = '0;
  logic dst_sign = 0, dst_snan = 0, src_sign = 0, src_snan = 0;
  logic rev_mode = 0, int_source = 0, zd_masked = 0;
  logic out_valid, out_ready = 1'b1;
  logic [1:0] res_cls;
  logic res_sign, flag_invalid, flag_zdiv, store_en, normal_path;

  int checks = 0, errors = 0;
  logic [6:0] exp_q[$];
  string tag_q[$];
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdiv_special_resolver u0 (.*);

  // expected: {cls[1:0], sign, invalid, zdiv, store, normal}
  function automatic logic [6:0] model(input logic [1:0] dc, input logic ds, dsn,
      input logic [1:0] sc, input logic ss, ssn, rv, isrc, zm, output string tag);
    logic [1:0] ac, bc; logic as_, bs, asn, bsn, x;
    logic [1:0] c; logic s, inv, zd, st, nm;
    if (isrc && sc == 2'd0) ss = 1'b0;
    if (rv) begin ac = sc; as_ = ss; asn = ssn; bc = dc; bs = ds; bsn = dsn; end
    else    begin ac = dc; as_ = ds; asn = dsn; bc = sc; bs = ss; bsn = ssn; end
    x = as_ ^ bs; c = 2'd1; s = x; inv = 0; zd = 0; st = 1; nm = 0;
    if (ac == 3 || bc == 3) begin
      tag = "R6"; c = 3; s = (ac == 3) ? as_ : bs;
      inv = (ac == 3 && asn) || (bc == 3 && bsn);
    end else if (ac == 2 && bc == 2) begin tag = "R1"; c = 3; s = 1; inv = 1; end
    else if (ac == 0 && bc == 0) begin tag = "R2"; c = 3; s = 1; inv = 1; end
    else if (ac == 1 && bc == 0) begin tag = "R3"; c = 2; zd = 1; st = zm; end
    else if (ac == 2) begin tag = "R5"; c = 2; end
    else if (bc == 2 || ac == 0) begin tag = "R4"; c = 0; end
    else begin tag = "R9"; nm = 1; end
    return {c, s, inv, zd, st, nm};
  endfunction

  task automatic send(input logic [1:0] dc, input logic ds, dsn, input logic [1:0] sc,
      input logic ss, ssn, rv, isrc, zm, input string force_tag);
    string t;
    logic [6:0] e;
    @(negedge clk);
    dst_cls = dc; dst_sign = ds; dst_snan = dsn; src_cls = sc; src_sign = ss;
    src_snan = ssn; rev_mode = rv; int_source = isrc; zd_masked = zm; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e = model(dc, ds, dsn, sc, ss, ssn, rv, isrc, zm, t);
    exp_q.push_back(e);
    tag_q.push_back(force_tag != "" ? force_tag : t);
    @(posedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= lfsr[0] | lfsr[2];
  end

  // monitor
  initial begin
    logic prev_stall; logic [6:0] prev_out, got, e; string t;
    prev_stall = 0; prev_out = '0;
    forever begin
      @(negedge clk); #1;
      got = {res_cls, res_sign, flag_invalid, flag_zdiv, store_en, normal_path};
      if (rst_n && prev_stall) begin
        checks++;
        if (!out_valid || got !== prev_out) begin
          errors++;
          $display("FAIL R10 held output changed: valid=%b got=%b exp=%b", out_valid, got, prev_out);
        end
      end
      if (rst_n && out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected output got=%b exp=none", got);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL %s verdict got=%b exp=%b", t, got, e);
          end
        end
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_out = got;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset state got valid=%b ready=%b exp valid=0 ready=1", out_valid, in_ready);
    end
    // directed cases
    send(2'd1, 0, 0, 2'd0, 1, 0, 0, 1, 1, "R7");  // int +0: inf sign 0
    send(2'd1, 1, 0, 2'd0, 1, 0, 0, 1, 1, "R7");  // int +0: inf sign 1
    send(2'd1, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R3");  // unmasked: no store
    send(2'd0, 0, 0, 2'd1, 1, 0, 1, 0, 1, "R8");  // reverse: finite/zero
    send(2'd1, 0, 0, 2'd0, 0, 0, 1, 0, 1, "R8");  // reverse: zero/finite
    send(2'd3, 0, 1, 2'd3, 1, 0, 0, 0, 1, "R6");
    send(2'd2, 1, 0, 2'd2, 1, 0, 0, 0, 1, "R1");
    send(2'd0, 0, 0, 2'd0, 1, 0, 1, 0, 0, "R2");
    // sweep
    for (int dc = 0; dc < 4; dc++)
      for (int sc = 0; sc < 4; sc++)
        for (int k = 0; k < 32; k++)
          send(dc[1:0], k[0], k[0] ^ k[2], sc[1:0], k[1], k[3], k[2], k[3] ^ k[4], k[4], "");
    @(negedge clk); in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule